// File: doc/BRIEF.md
# Latched Fault Protection Supervisor

This block decides, every clock, whether the power output stage of a two-phase motor driver may conduct. It merges a supply-good flag, a thermal fault flag, an over-current fault flag, an output enable and a two-bit step-mode selector into a single permit. All inputs arrive already synchronized to the block clock. The analog detectors that produce the fault flags are outside the block.

Thermal and over-current events are caught in sticky latches. A fault input must stay high for a programmable number of consecutive samples before it latches, so short spikes are filtered out. Once set, a latch holds the output stage off even after the cause has gone away. Only two conditions release it: the supply-good flag dropping, or the mode selector being parked at the standby code. The same mode code also stops the chopping oscillator.

Top module: `fault_permit_guard`

## Requirements
- R1: While `rst_n` is low, both fault latches read 0. After reset, with supply good, enable high and a run mode, `stage_on` is high.
- R2: `temp_latched` becomes 1 after the clock edge at which `temp_flt` has been sampled high on FILT_LEN consecutive edges with no clear condition. A high burst shorter than FILT_LEN samples leaves the latch at 0 and `stage_on` high.
- R3: `curr_latched` follows the same filter and latch rule as R2, driven by `curr_flt`.
- R4: A set latch stays 1 after its fault input returns low, for as long as `por_ok` is 1 and `mode` is not 2'b00.
- R5: Sampling `por_ok` at 0 clears both latches on that edge. While `por_ok` is 0, `stage_on` is 0 and the latches cannot be set.
- R6: `mode` 2'b00 is standby. Sampling it clears both latches and resets both filters. In standby, `osc_run` and `stage_on` are 0.
- R7: With `en` at 0, `stage_on` is 0. The latches are left unchanged, so a latch set beforehand is still 1 once `en` returns high.
- R8: `stage_on` is 1 exactly when `por_ok` is 1, `en` is 1, `mode` is not 2'b00 and neither latch is set.
- R9: The filters hold at zero while a clear condition is sampled. A fault input still high when the clear ends latches again on the FILT_LEN-th consecutive high sample after the clear ends.
- R10: The mode codes 2'b01, 2'b10 and 2'b11 are run modes. In each of them `osc_run` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply above power-on threshold |
| temp_flt | input | 1 | Raw thermal fault flag |
| curr_flt | input | 1 | Raw over-current fault flag |
| en | input | 1 | Output stage enable |
| mode | input | 2 | Step-mode selector; 2'b00 is standby |
| stage_on | output | 1 | Output stage permitted to conduct |
| temp_latched | output | 1 | Sticky thermal fault |
| curr_latched | output | 1 | Sticky over-current fault |
| osc_run | output | 1 | Chopping oscillator run request |

## Verification
The bench builds the block with FILT_LEN = 3 rather than the default of 2. At that length a two-sample fault burst is a real glitch that must be rejected, distinct from a qualifying three-sample run. This lets the bench check where the filter boundary falls on both sides. It also makes the restart of the filter after a clear visible as a two-cycle gap before the fault latches again.

// File: rtl/fault_permit_guard.sv
module fault_permit_guard #(
  parameter int FILT_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       temp_flt,
  input  logic       curr_flt,
  input  logic       en,
  input  logic [1:0] mode,
  output logic       stage_on,
  output logic       temp_latched,
  output logic       curr_latched,
  output logic       osc_run
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LIM = CW'(FILT_LEN - 1);

  logic       standby;
  logic       clr;
  logic [1:0] flt_in;
  logic [1:0] flt_lat;

  assign standby = (mode == 2'b00);
  assign clr     = standby | ~por_ok;
  assign flt_in  = {curr_flt, temp_flt};

  for (genvar g = 0; g < 2; g++) begin : g_chan
    logic [CW-1:0] run;
    logic          lat;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run <= '0;
        lat <= 1'b0;
      end else if (clr) begin
        run <= '0;
        lat <= 1'b0;
      end else if (flt_in[g]) begin
        run <= (run == LIM) ? LIM : run + 1'b1;
        if (run == LIM) lat <= 1'b1;
      end else begin
        run <= '0;
      end
    end

    assign flt_lat[g] = lat;
  end

  assign temp_latched = flt_lat[0];
  assign curr_latched = flt_lat[1];
  assign osc_run      = ~standby;
  assign stage_on     = por_ok & en & ~standby & ~|flt_lat;

  assert_set_needs_heat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(temp_latched) |-> $past(temp_flt));

  assert_set_needs_current_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(curr_latched) |-> $past(curr_flt));

  assert_hold_heat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_latched && por_ok && mode != 2'b00) |=> temp_latched);

  assert_hold_current_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (curr_latched && por_ok && mode != 2'b00) |=> curr_latched);

  assert_clear_on_supply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> (!temp_latched && !curr_latched));

  assert_clear_on_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (!temp_latched && !curr_latched));

  assert_standby_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (!osc_run && !stage_on));

  assert_latch_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_latched || curr_latched) |-> !stage_on);
endmodule

// File: tb/fault_permit_guard_tb_top.sv
module fault_permit_guard_tb_top;
  localparam int F = 3;

  logic clk = 1'b0;
  logic rst_n, por_ok, temp_flt, curr_flt, en;
  logic [1:0] mode;
  logic stage_on, temp_latched, curr_latched, osc_run;

  always #2.5 clk = ~clk;

  fault_permit_guard #(.FILT_LEN(F)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .temp_flt(temp_flt),
    .curr_flt(curr_flt), .en(en), .mode(mode), .stage_on(stage_on),
    .temp_latched(temp_latched), .curr_latched(curr_latched), .osc_run(osc_run));

  typedef struct {
    logic  s, t, c, o;
    string tag;
  } item_t;

  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int  m_tc = 0, m_cc = 0;
  logic m_tl = 1'b0, m_cl = 1'b0;

  task automatic step(input logic r, input logic p, input logic t, input logic c,
                      input logic e, input logic [1:0] m, input string tag);
    item_t it;
    @(negedge clk);
    rst_n = r; por_ok = p; temp_flt = t; curr_flt = c; en = e; mode = m;
    if (!r || !p || m == 2'b00) begin
      m_tc = 0; m_cc = 0; m_tl = 1'b0; m_cl = 1'b0;
    end else begin
      if (t) begin
        if (m_tc + 1 >= F) m_tl = 1'b1;
        m_tc = (m_tc + 1 >= F) ? F : m_tc + 1;
      end else m_tc = 0;
      if (c) begin
        if (m_cc + 1 >= F) m_cl = 1'b1;
        m_cc = (m_cc + 1 >= F) ? F : m_cc + 1;
      end else m_cc = 0;
    end
    it.t = m_tl;
    it.c = m_cl;
    it.o = (m != 2'b00);
    it.s = p && e && (m != 2'b00) && !m_tl && !m_cl;
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      compared++;
      if ({stage_on, temp_latched, curr_latched, osc_run} !== {it.s, it.t, it.c, it.o}) begin
        mismatched++;
        $display("FAIL %s: got stage/temp/curr/osc=%b%b%b%b expected %b%b%b%b",
                 it.tag, stage_on, temp_latched, curr_latched, osc_run,
                 it.s, it.t, it.c, it.o);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; por_ok = 1'b1; temp_flt = 1'b0; curr_flt = 1'b0; en = 1'b1; mode = 2'b01;
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 1, 2'b01, "R1 reset");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 1, 2'b01, "R1 R8 run");
    step(1, 1, 0, 0, 1, 2'b10, "R10 mode10");
    step(1, 1, 0, 0, 1, 2'b11, "R10 mode11");
    for (int i = 0; i < F - 1; i++) step(1, 1, 1, 0, 1, 2'b01, "R2 glitch");
    step(1, 1, 0, 0, 1, 2'b01, "R2 glitch gone");
    for (int i = 0; i < F; i++) step(1, 1, 1, 0, 1, 2'b01, "R2 latch");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 1, 2'b01, "R4 hold heat");
    step(1, 1, 0, 0, 0, 2'b01, "R7 disabled");
    step(1, 1, 0, 0, 1, 2'b10, "R7 R4 latch kept");
    step(1, 1, 0, 0, 1, 2'b00, "R6 standby clear");
    step(1, 1, 1, 1, 1, 2'b00, "R6 standby blocks");
    step(1, 1, 0, 0, 1, 2'b11, "R6 resume");
    step(1, 1, 0, 0, 0, 2'b11, "R7 en low");
    step(1, 1, 0, 0, 1, 2'b11, "R8 permit back");
    for (int i = 0; i < F - 1; i++) step(1, 1, 0, 1, 1, 2'b01, "R3 glitch");
    step(1, 1, 0, 0, 1, 2'b01, "R3 glitch gone");
    for (int i = 0; i < F; i++) step(1, 1, 0, 1, 1, 2'b01, "R3 latch");
    step(1, 1, 0, 0, 1, 2'b01, "R4 hold current");
    step(1, 1, 0, 1, 1, 2'b01, "R3 refault");
    for (int i = 0; i < 2; i++) step(1, 0, 0, 1, 1, 2'b01, "R5 supply low");
    for (int i = 0; i < F + 1; i++) step(1, 1, 0, 1, 1, 2'b01, "R9 relatch supply");
    step(1, 1, 0, 0, 1, 2'b00, "R6 clear current");
    for (int i = 0; i < 2; i++) step(1, 1, 1, 0, 1, 2'b00, "R9 heat in standby");
    for (int i = 0; i < F + 1; i++) step(1, 1, 1, 0, 1, 2'b10, "R9 relatch standby");
    step(1, 1, 1, 1, 1, 2'b00, "R6 both clear");
    for (int i = 0; i < F; i++) step(1, 1, 1, 1, 1, 2'b11, "R2 R3 both");
    step(1, 0, 0, 0, 1, 2'b11, "R5 both clear");
    step(1, 1, 0, 0, 1, 2'b11, "R8 final run");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule